// File: doc/BRIEF.md
# Bank-Conflict-Aware Oldest-First Memory Command Selector

This block sits between two reorder queues of pending DRAM commands (one for reads, one for writes) and a short in-order issue FIFO that feeds the DRAM command path. Each cycle it looks at every queued command and drops from consideration any whose bank is still busy from a command that recently left the FIFO for DRAM. Of what remains, it moves the command that arrived earliest, whichever queue holds it, into the FIFO. The FIFO then hands commands to DRAM strictly in the order they were chosen, under a valid/ready handshake.

Requesters push reads and writes on separate ports. A push that meets a full queue is turned away in the same cycle and must be retried later. Every accepted command gets a global arrival sequence number. The entry with the largest distance from the current sequence counter is the oldest. A bank counts as busy for a fixed number of memory cycles after a command to it is handed to DRAM. With both queues empty, every entry blocked, or the FIFO full, nothing moves.

Top module: `cmd_oldest_sel`

## Requirements
- R1: Each reorder queue holds `Q_DEPTH` (8) commands. A push to a full queue asserts that queue's reject output in the same cycle, and the command is not stored. A queue counts as full on its occupancy at the start of the cycle, even if an entry leaves it in that same cycle.
- R2: The issue FIFO presents its head on the `dram_*` outputs whenever it is non-empty. It removes the head only when `dram_valid` and `dram_ready` are both high. While `dram_ready` is low, the head and `dram_valid` hold steady.
- R3: A bank is identified by the triple (port, rank, bank). It is busy for `BANK_BUSY_CYC` (20) clock edges following the edge at which a command to it is handed to DRAM. A queued command to a busy bank is never selected in that window.
- R4: Among queued commands whose bank is free, the one accepted earliest is selected. A read and a write accepted in the same cycle count the read as earlier.
- R5: The issue FIFO holds `FIFO_DEPTH` (4) commands. When it holds that many at the start of a cycle, no command is selected in that cycle, even if the head leaves.
- R6: When no queued command is eligible, no command enters the FIFO and the queue contents are unchanged.
- R7: After synchronous reset, both queues and the FIFO are empty, all banks are free, and `dram_valid` is low.
- R8: A selected command enters the FIFO at the clock edge that ends the cycle of its selection. The order of commands on the `dram_*` outputs equals the order of selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_valid | input | 1 | Read command push |
| rd_req_port | input | 1 | Read target port |
| rd_req_rank | input | 2 | Read target rank |
| rd_req_bank | input | 2 | Read target bank |
| rd_req_row | input | 14 | Read target row |
| rd_req_reject | output | 1 | Read push refused, queue full |
| wr_req_valid | input | 1 | Write command push |
| wr_req_port | input | 1 | Write target port |
| wr_req_rank | input | 2 | Write target rank |
| wr_req_bank | input | 2 | Write target bank |
| wr_req_row | input | 14 | Write target row |
| wr_req_reject | output | 1 | Write push refused, queue full |
| dram_valid | output | 1 | FIFO head is valid |
| dram_ready | input | 1 | DRAM accepts the head this cycle |
| dram_is_wr | output | 1 | Head is a write (1) or read (0) |
| dram_port | output | 1 | Head port |
| dram_rank | output | 2 | Head rank |
| dram_bank | output | 2 | Head bank |
| dram_row | output | 14 | Head row |

## Verification
The bench builds the block with its default parameters: queues of 8, a FIFO of 4 and a 20-cycle bank window. At these sizes it can fill the FIFO and both queues within a few dozen cycles. This reaches the reject path and the full-FIFO stall. The short busy window lets the bench send a younger command to a free bank ahead of an older blocked one, and then watch the blocked one go out on the exact cycle its bank frees. A long random phase confined to eight banks keeps conflicts frequent, so the oldest-eligible choice is exercised under heavy contention.

// File: rtl/cmdsel_pkg.sv
package cmdsel_pkg;

    parameter int PORTS = 2;
    parameter int RANKS = 4;
    parameter int BANKS = 4;
    parameter int ROW_W = 14;
    parameter int SEQ_W = 8;

    localparam int PORT_W   = (PORTS > 1) ? $clog2(PORTS) : 1;
    localparam int RANK_W   = (RANKS > 1) ? $clog2(RANKS) : 1;
    localparam int BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1;
    localparam int NUM_BANK = PORTS * RANKS * BANKS;
    localparam int BID_W    = $clog2(NUM_BANK);

    typedef struct packed {
        logic              is_wr;
        logic [PORT_W-1:0] port;
        logic [RANK_W-1:0] rank;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
    } mem_cmd_t;

    typedef logic [SEQ_W-1:0] seq_t;

    function automatic logic [BID_W-1:0] bank_id(mem_cmd_t c);
        int unsigned v;
        v = (int'(unsigned'(c.port)) * RANKS + int'(unsigned'(c.rank))) * BANKS
            + int'(unsigned'(c.bank));
        return BID_W'(v);
    endfunction

endpackage

// File: rtl/cmd_slot_store.sv
module cmd_slot_store
    import cmdsel_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push_valid,
    input  mem_cmd_t              push_cmd,
    input  seq_t                  push_seq,
    output logic                  full,
    output logic [DEPTH-1:0]      slot_valid,
    output mem_cmd_t [DEPTH-1:0]  slot_cmd,
    output seq_t [DEPTH-1:0]      slot_seq,
    input  logic                  pop_en,
    input  logic [IDX_W-1:0]      pop_idx
);

    logic [IDX_W-1:0] free_idx;
    logic             do_push;

    assign full    = &slot_valid;
    assign do_push = push_valid && !full;

    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!slot_valid[i]) free_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_valid <= '0;
        end else begin
            if (pop_en)  slot_valid[pop_idx]  <= 1'b0;
            if (do_push) slot_valid[free_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            slot_cmd[free_idx] <= push_cmd;
            slot_seq[free_idx] <= push_seq;
        end
    end

    // R6: only an occupied slot may be removed
    a_r6_pop_occupied: assert property (@(posedge clk) disable iff (rst)
        pop_en |-> slot_valid[pop_idx]);

    // R1: a refused push leaves stored commands untouched
    a_r1_full_no_store: assert property (@(posedge clk) disable iff (rst)
        (full && push_valid && !pop_en) |=> $stable(slot_valid));

endmodule

// File: rtl/bank_timer.sv
module bank_timer #(
    parameter int NUM  = 32,
    parameter int BUSY = 20,
    localparam int IDX_W = $clog2(NUM),
    localparam int CNT_W = $clog2(BUSY + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_idx,
    output logic [NUM-1:0]   busy
);

    for (genvar g = 0; g < NUM; g++) begin : g_bank
        logic [CNT_W-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst)                                  cnt <= '0;
            else if (load_en && load_idx == IDX_W'(g)) cnt <= CNT_W'(BUSY);
            else if (cnt != '0)                       cnt <= cnt - 1'b1;
        end
        assign busy[g] = (cnt != '0);
    end

    // R3: issuing to a bank makes it busy on the next cycle
    a_r3_busy_after_issue: assert property (@(posedge clk) disable iff (rst)
        load_en |=> busy[$past(load_idx)]);

endmodule

// File: rtl/issue_fifo.sv
module issue_fifo
    import cmdsel_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push_en,
    input  mem_cmd_t push_cmd,
    output logic     full,
    output logic     out_valid,
    output mem_cmd_t out_cmd,
    input  logic     out_ready
);

    mem_cmd_t [DEPTH-1:0] mem;
    logic [IDX_W-1:0]     rd_ptr, wr_ptr;
    logic [CNT_W-1:0]     count;
    logic                 pop;

    assign full      = (count == CNT_W'(DEPTH));
    assign out_valid = (count != '0);
    assign out_cmd   = mem[rd_ptr];
    assign pop       = out_valid && out_ready;

    function automatic logic [IDX_W-1:0] bump(logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_en) wr_ptr <= bump(wr_ptr);
            if (pop)     rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push_en) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push_en) mem[wr_ptr] <= push_cmd;
    end

    // R5: the selector never pushes into a full FIFO
    a_r5_no_push_full: assert property (@(posedge clk) disable iff (rst)
        push_en |-> !full);

    // R2: a stalled head stays valid and unchanged
    a_r2_head_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_cmd)));

endmodule

// File: rtl/cmd_oldest_sel.sv
module cmd_oldest_sel
    import cmdsel_pkg::*;
#(
    parameter int Q_DEPTH       = 8,
    parameter int FIFO_DEPTH    = 4,
    parameter int BANK_BUSY_CYC = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req_valid,
    input  logic [PORT_W-1:0] rd_req_port,
    input  logic [RANK_W-1:0] rd_req_rank,
    input  logic [BANK_W-1:0] rd_req_bank,
    input  logic [ROW_W-1:0]  rd_req_row,
    output logic              rd_req_reject,
    input  logic              wr_req_valid,
    input  logic [PORT_W-1:0] wr_req_port,
    input  logic [RANK_W-1:0] wr_req_rank,
    input  logic [BANK_W-1:0] wr_req_bank,
    input  logic [ROW_W-1:0]  wr_req_row,
    output logic              wr_req_reject,
    output logic              dram_valid,
    input  logic              dram_ready,
    output logic              dram_is_wr,
    output logic [PORT_W-1:0] dram_port,
    output logic [RANK_W-1:0] dram_rank,
    output logic [BANK_W-1:0] dram_bank,
    output logic [ROW_W-1:0]  dram_row
);

    localparam int NCAND  = 2 * Q_DEPTH;
    localparam int CAND_W = $clog2(NCAND);
    localparam int SLOT_W = $clog2(Q_DEPTH);

    seq_t                   next_seq;
    logic                   rd_full, wr_full, rd_acc, wr_acc;
    mem_cmd_t               rd_in, wr_in;
    logic [Q_DEPTH-1:0]     rd_sv, wr_sv;
    mem_cmd_t [Q_DEPTH-1:0] rd_sc, wr_sc;
    seq_t [Q_DEPTH-1:0]     rd_ss, wr_ss;
    logic [NCAND-1:0]       cand_v;
    mem_cmd_t [NCAND-1:0]   cand_c;
    seq_t [NCAND-1:0]       cand_s;
    logic [NUM_BANK-1:0]    bank_busy;
    logic                   fifo_full;
    mem_cmd_t               fifo_out;
    logic                   pick_found, sel_en, rd_pop, wr_pop;
    logic [CAND_W-1:0]      pick_idx;
    seq_t                   best_age, age;

    assign rd_in = '{is_wr: 1'b0, port: rd_req_port, rank: rd_req_rank,
                     bank: rd_req_bank, row: rd_req_row};
    assign wr_in = '{is_wr: 1'b1, port: wr_req_port, rank: wr_req_rank,
                     bank: wr_req_bank, row: wr_req_row};

    assign rd_acc        = rd_req_valid && !rd_full;
    assign wr_acc        = wr_req_valid && !wr_full;
    assign rd_req_reject = rd_req_valid && rd_full;
    assign wr_req_reject = wr_req_valid && wr_full;

    always_ff @(posedge clk) begin
        if (rst) next_seq <= '0;
        else     next_seq <= next_seq + SEQ_W'(rd_acc) + SEQ_W'(wr_acc);
    end

    cmd_slot_store #(.DEPTH(Q_DEPTH)) u_rd_store (
        .clk(clk), .rst(rst),
        .push_valid(rd_req_valid), .push_cmd(rd_in), .push_seq(next_seq),
        .full(rd_full), .slot_valid(rd_sv), .slot_cmd(rd_sc), .slot_seq(rd_ss),
        .pop_en(rd_pop), .pop_idx(pick_idx[SLOT_W-1:0])
    );

    cmd_slot_store #(.DEPTH(Q_DEPTH)) u_wr_store (
        .clk(clk), .rst(rst),
        .push_valid(wr_req_valid), .push_cmd(wr_in),
        .push_seq(next_seq + SEQ_W'(rd_acc)),
        .full(wr_full), .slot_valid(wr_sv), .slot_cmd(wr_sc), .slot_seq(wr_ss),
        .pop_en(wr_pop), .pop_idx(pick_idx[SLOT_W-1:0])
    );

    assign cand_v = {wr_sv, rd_sv};
    assign cand_c = {wr_sc, rd_sc};
    assign cand_s = {wr_ss, rd_ss};

    // oldest eligible: largest distance behind the arrival counter
    always_comb begin
        pick_found = 1'b0;
        pick_idx   = '0;
        best_age   = '0;
        age        = '0;
        for (int i = 0; i < NCAND; i++) begin
            if (cand_v[i] && !bank_busy[bank_id(cand_c[i])]) begin
                age = next_seq - cand_s[i];
                if (!pick_found || age > best_age) begin
                    pick_found = 1'b1;
                    pick_idx   = CAND_W'(i);
                    best_age   = age;
                end
            end
        end
    end

    assign sel_en = pick_found && !fifo_full;
    assign rd_pop = sel_en && !pick_idx[CAND_W-1];
    assign wr_pop = sel_en &&  pick_idx[CAND_W-1];

    issue_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push_en(sel_en), .push_cmd(cand_c[pick_idx]), .full(fifo_full),
        .out_valid(dram_valid), .out_cmd(fifo_out), .out_ready(dram_ready)
    );

    bank_timer #(.NUM(NUM_BANK), .BUSY(BANK_BUSY_CYC)) u_timer (
        .clk(clk), .rst(rst),
        .load_en(dram_valid && dram_ready), .load_idx(bank_id(fifo_out)),
        .busy(bank_busy)
    );

    assign dram_is_wr = fifo_out.is_wr;
    assign dram_port  = fifo_out.port;
    assign dram_rank  = fifo_out.rank;
    assign dram_bank  = fifo_out.bank;
    assign dram_row   = fifo_out.row;

    // R6: with both queues empty nothing is selected
    a_r6_empty_idle: assert property (@(posedge clk) disable iff (rst)
        (!(|rd_sv) && !(|wr_sv)) |-> !sel_en);

    // R8: a selection makes the FIFO non-empty on the next cycle
    a_r8_sel_lands: assert property (@(posedge clk) disable iff (rst)
        sel_en |=> dram_valid);

endmodule

// File: tb/cmd_oldest_sel_tb.sv
`timescale 1ns/1ps
module cmd_oldest_sel_tb;

    localparam int QD = 8, FD = 4, BUSY = 20, NB = 32;

    logic clk = 1'b0, rst = 1'b1;
    logic rd_req_valid = 0, wr_req_valid = 0, dram_ready = 0;
    logic [0:0]  rd_req_port = 0, wr_req_port = 0;
    logic [1:0]  rd_req_rank = 0, rd_req_bank = 0, wr_req_rank = 0, wr_req_bank = 0;
    logic [13:0] rd_req_row = 0, wr_req_row = 0;
    logic rd_req_reject, wr_req_reject, dram_valid, dram_is_wr;
    logic [0:0]  dram_port;
    logic [1:0]  dram_rank, dram_bank;
    logic [13:0] dram_row;

    always #2.5 clk = ~clk;

    cmd_oldest_sel u_dut (
        .clk(clk), .rst(rst),
        .rd_req_valid(rd_req_valid), .rd_req_port(rd_req_port), .rd_req_rank(rd_req_rank),
        .rd_req_bank(rd_req_bank), .rd_req_row(rd_req_row), .rd_req_reject(rd_req_reject),
        .wr_req_valid(wr_req_valid), .wr_req_port(wr_req_port), .wr_req_rank(wr_req_rank),
        .wr_req_bank(wr_req_bank), .wr_req_row(wr_req_row), .wr_req_reject(wr_req_reject),
        .dram_valid(dram_valid), .dram_ready(dram_ready), .dram_is_wr(dram_is_wr),
        .dram_port(dram_port), .dram_rank(dram_rank), .dram_bank(dram_bank), .dram_row(dram_row)
    );

    typedef struct {
        int stamp; bit wr; int port; int rank; int bank; int row;
    } ent_t;

    ent_t pend[$];
    ent_t fq[$];
    int   busy[NB];
    int   stamp_ctr, rcnt, wcnt;
    int   tests = 0, fails = 0;

    function automatic int bid(ent_t e);
        return (e.port * 4 + e.rank) * 4 + e.bank;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        pend.delete(); fq.delete();
        for (int b = 0; b < NB; b++) busy[b] = 0;
        stamp_ctr = 0; rcnt = 0; wcnt = 0;
    endtask

    task automatic compare(string tag);
        logic [19:0] act, exp;
        chk(dram_valid === (fq.size() > 0), tag, 32'(dram_valid), 32'(fq.size() > 0));
        if (fq.size() > 0) begin
            act = {dram_is_wr, dram_port, dram_rank, dram_bank, dram_row};
            exp = {fq[0].wr, 1'(fq[0].port), 2'(fq[0].rank), 2'(fq[0].bank), 14'(fq[0].row)};
            chk(act === exp, tag, 32'(act), 32'(exp));
        end
        chk(rd_req_reject === (rd_req_valid && rcnt == QD), "R1 rd reject",
            32'(rd_req_reject), 32'(rd_req_valid && rcnt == QD));
        chk(wr_req_reject === (wr_req_valid && wcnt == QD), "R1 wr reject",
            32'(wr_req_reject), 32'(wr_req_valid && wcnt == QD));
    endtask

    task automatic model_step();
        int pre_f, pre_r, pre_w, best, ld;
        bit issue;
        ent_t e;
        pre_f = fq.size(); pre_r = rcnt; pre_w = wcnt;
        issue = (pre_f > 0) && dram_ready;
        best = -1;
        if (pre_f < FD) begin
            for (int k = 0; k < pend.size(); k++)
                if (busy[bid(pend[k])] == 0 && (best < 0 || pend[k].stamp < pend[best].stamp))
                    best = k;
        end
        ld = -1;
        if (issue) begin e = fq.pop_front(); ld = bid(e); end
        if (best >= 0) begin
            fq.push_back(pend[best]);
            if (pend[best].wr) wcnt--; else rcnt--;
            pend.delete(best);
        end
        for (int b = 0; b < NB; b++) begin
            if (b == ld)          busy[b] = BUSY;
            else if (busy[b] > 0) busy[b]--;
        end
        if (rd_req_valid && pre_r < QD) begin
            e = '{stamp_ctr, 1'b0, int'(rd_req_port), int'(rd_req_rank),
                  int'(rd_req_bank), int'(rd_req_row)};
            pend.push_back(e); stamp_ctr++; rcnt++;
        end
        if (wr_req_valid && pre_w < QD) begin
            e = '{stamp_ctr, 1'b1, int'(wr_req_port), int'(wr_req_rank),
                  int'(wr_req_bank), int'(wr_req_row)};
            pend.push_back(e); stamp_ctr++; wcnt++;
        end
    endtask

    // drive one cycle (called just after a falling edge)
    task automatic cyc(bit rv, int rp, int rr, int rb, int rrow,
                       bit wv, int wp, int wr_, int wb, int wrow,
                       bit rdy, string tag);
        rd_req_valid = rv; rd_req_port = 1'(rp); rd_req_rank = 2'(rr);
        rd_req_bank = 2'(rb); rd_req_row = 14'(rrow);
        wr_req_valid = wv; wr_req_port = 1'(wp); wr_req_rank = 2'(wr_);
        wr_req_bank = 2'(wb); wr_req_row = 14'(wrow);
        dram_ready = rdy;
        #1;
        compare(tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle(int n, bit rdy, string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, rdy, tag);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R7: empty after reset
        chk(dram_valid === 1'b0, "R7 dram_valid", 32'(dram_valid), 0);
        chk(rd_req_reject === 1'b0 && wr_req_reject === 1'b0, "R7 rejects",
            32'({rd_req_reject, wr_req_reject}), 0);
        @(negedge clk);

        // R2: single read then single write flow through
        cyc(1, 0, 0, 1, 100, 0, 0, 0, 0, 0, 1, "R2");
        idle(3, 1, "R2");
        cyc(0, 0, 0, 0, 0, 1, 1, 2, 3, 200, 0, "R2");
        idle(4, 0, "R2 hold");
        idle(3, 1, "R2");

        // R4: simultaneous pair (read counts as older), then mixed arrivals, FIFO stalled
        cyc(1, 0, 1, 0, 11, 1, 0, 1, 1, 12, 0, "R4");
        cyc(0, 0, 0, 0, 0, 1, 0, 1, 2, 13, 0, "R4");
        cyc(1, 0, 1, 3, 14, 0, 0, 0, 0, 0, 0, "R4");
        cyc(1, 0, 2, 0, 15, 1, 0, 2, 1, 16, 0, "R4");
        cyc(0, 0, 0, 0, 0, 1, 0, 2, 2, 17, 0, "R4");
        idle(3, 0, "R8 order");
        idle(30, 1, "R8 order");

        // R3: younger command to a free bank overtakes an older blocked one
        cyc(1, 0, 3, 2, 300, 0, 0, 0, 0, 0, 1, "R3");
        idle(3, 1, "R3");
        cyc(1, 0, 3, 2, 301, 0, 0, 0, 0, 0, 1, "R3");
        cyc(0, 0, 0, 0, 0, 1, 1, 0, 0, 302, 1, "R3");
        idle(30, 1, "R3");

        // R6: every entry blocked on one bank
        cyc(1, 1, 1, 1, 400, 0, 0, 0, 0, 0, 1, "R6");
        idle(2, 1, "R6");
        cyc(1, 1, 1, 1, 401, 1, 1, 1, 1, 402, 1, "R6");
        idle(60, 1, "R6");

        // R1 and R5: fill FIFO and both queues, then keep pushing
        for (int i = 0; i < 16; i++)
            cyc(1, i % 2, i % 4, (i / 4) % 4, 500 + i, 1, 1, i % 4, 3 - (i % 4), 600 + i, 0, "R1");
        for (int i = 0; i < 5; i++)
            cyc(1, 0, 0, 0, 700, 1, 0, 0, 0, 701, 0, "R5");
        idle(120, 1, "R5 drain");

        // contention mix on eight banks
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom);
            cyc(r[0], r[1], r[2], r[3], r[15:4] & 12'hfff, r[16], r[17], r[18], r[19],
                r[31:20] & 12'hfff, (r[21] | r[22] | r[23]), "R4 mix");
        end
        idle(200, 1, "R4 mix drain");

        summary();
        $finish;
    end

endmodule